// File: doc/BRIEF.md
# Sub-Band Gain Engine

This block applies per-band gains to one frame of frequency-domain sub-band data. The frame holds one complex sample per band, covering DC up to Nyquist (half the transform size). The engine reads each band and its gain from its own shared memory and writes the result back in place, where a later synthesis stage can use it. A pass runs in one of three modes. Real mode scales the magnitude only. Complex mode also rotates the phase. Energy mode leaves the band data alone and writes one power value per band into a separate region.

A host processor owns a simple word-addressed bus. Through it the host can read and write every memory region at any time and reach three control registers. Writing the start bit launches a pass over the configured number of bands. The engine handles one band every two clock cycles. When the pass ends it raises an interrupt, which stays high until the host acknowledges it.

The host address is split into a 2-bit region field (the top two bits) and a band index (the low bits). Region 0 holds the registers, region 1 the band data, region 2 the gains and region 3 the energy values. Data and gain words carry the real part in bits [31:16] and the imaginary part in bits [15:0]. Both parts are signed Q1.15.

Top module: `subband_gain_engine`

## Requirements
- R1: After reset, STATUS reads 0, CTRL reads 0, NBANDS reads MAX_BANDS, and `irq` is low.
- R2: In real mode (CTRL mode 0), each processed band's real and imaginary parts are both multiplied by the real part of its gain word. Each product is rounded half-up to Q1.15, which means adding 2^14 and then shifting right arithmetically by 15. The result is then saturated to the range [-32768, 32767].
- R3: In complex mode (CTRL mode 1), the result is (dr·gr − di·gi) + j(dr·gi + di·gr). Each sum is rounded and saturated as in R2.
- R4: In energy mode (CTRL mode 2), energy word i becomes dr²+di² as an unsigned 32-bit value, and the band data stays unchanged.
- R5: A pass touches only bands 0 to NBANDS−1. All data and energy words at higher indices keep their previous values.
- R6: A write to NBANDS while idle stores the value clamped to the range 1 to MAX_BANDS: 0 becomes 1, and anything above MAX_BANDS becomes MAX_BANDS.
- R7: `done` (STATUS bit 1) and `irq` go high on the (2·NBANDS+1)-th rising edge after the edge that accepts the start write. Busy (STATUS bit 0) stays high in between.
- R8: While busy, writes to CTRL and NBANDS are ignored. A start request neither restarts the pass nor changes its mode.
- R9: Writing STATUS with bit 1 set clears `done` and `irq`. Writing it with bit 1 clear leaves them unchanged. An accepted start also clears `done`.
- R10: `host_rdata` returns the addressed word one cycle after `host_rd`. The register offsets within region 0 are CTRL=0, NBANDS=1 and STATUS=2. In CTRL, bit 0 is start and bits [2:1] are the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Region (top 2 bits) and index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| irq | output | 1 | Pass-complete interrupt, level |

## Verification
The bench builds the engine with MAX_BANDS=8. At that size a full-frame pass takes only 17 cycles, and an NBANDS write of 20 reaches the upper clamp. Each pass loads the frame with random words plus the extreme values −1 and just-below-one. Several passes use fewer bands than the frame holds, so the untouched tail of data and energy words is compared as well. One pass carries a start request issued mid-flight, which must change neither the mode nor the completion time.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 32;
    localparam int FRAC_W   = 15;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_CPLX   = 2'd1,
        MODE_ENERGY = 2'd2,
        MODE_RSVD   = 2'd3
    } gain_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RGN_REGS   = 2'd0,
        RGN_DATA   = 2'd1,
        RGN_GAIN   = 2'd2,
        RGN_ENERGY = 2'd3
    } region_e;

    localparam logic [1:0] OFF_CTRL   = 2'd0;
    localparam logic [1:0] OFF_NBANDS = 2'd1;
    localparam logic [1:0] OFF_STATUS = 2'd2;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] re;
        logic signed [SAMPLE_W-1:0] im;
    } cplx_t;

    // Q2.30 accumulator -> Q1.15 with round-half-up and saturation
    function automatic logic signed [SAMPLE_W-1:0] round_sat(input logic signed [33:0] acc);
        logic signed [33:0] r;
        r = (acc + 34'sd16384) >>> FRAC_W;
        if (r > 34'sd32767)
            return 16'sh7FFF;
        else if (r < -34'sd32768)
            return 16'sh8000;
        else
            return r[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/sbg_mem.sv
module sbg_mem
    import sbg_pkg::*;
#(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS)
) (
    input  logic              clk,
    // host port
    input  logic              h_we_data,
    input  logic              h_we_gain,
    input  logic              h_we_energy,
    input  logic [BAND_AW-1:0] h_idx,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_data,
    output logic [WORD_W-1:0] h_gain,
    output logic [WORD_W-1:0] h_energy,
    // engine port
    input  logic [BAND_AW-1:0] e_rd_idx,
    output cplx_t             e_data,
    output cplx_t             e_gain,
    input  logic              e_we_data,
    input  logic              e_we_energy,
    input  logic [BAND_AW-1:0] e_wr_idx,
    input  logic [WORD_W-1:0] e_wdata
);

    logic [WORD_W-1:0] data_q   [MAX_BANDS];
    logic [WORD_W-1:0] gain_q   [MAX_BANDS];
    logic [WORD_W-1:0] energy_q [MAX_BANDS];

    // engine write placed last so it wins a same-index collision
    always_ff @(posedge clk) begin
        if (h_we_data)   data_q[h_idx]   <= h_wdata;
        if (h_we_gain)   gain_q[h_idx]   <= h_wdata;
        if (h_we_energy) energy_q[h_idx] <= h_wdata;
        if (e_we_data)   data_q[e_wr_idx]   <= e_wdata;
        if (e_we_energy) energy_q[e_wr_idx] <= e_wdata;
    end

    assign h_data   = data_q[h_idx];
    assign h_gain   = gain_q[h_idx];
    assign h_energy = energy_q[h_idx];
    assign e_data   = cplx_t'(data_q[e_rd_idx]);
    assign e_gain   = cplx_t'(gain_q[e_rd_idx]);

endmodule

// File: rtl/sbg_regs.sv
module sbg_regs
    import sbg_pkg::*;
#(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS),
    localparam int NB_W = BAND_AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_off,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    input  logic              finish,
    output logic              start,
    output gain_mode_e        mode,
    output logic [NB_W-1:0]   nbands,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);

    logic wr_ctrl, wr_nb, wr_stat;

    assign wr_ctrl = reg_wr && (reg_off == OFF_CTRL)   && !busy;
    assign wr_nb   = reg_wr && (reg_off == OFF_NBANDS) && !busy;
    assign wr_stat = reg_wr && (reg_off == OFF_STATUS);
    assign start   = wr_ctrl && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_REAL;
            nbands <= NB_W'(MAX_BANDS);
            done   <= 1'b0;
        end else begin
            if (wr_ctrl)
                mode <= gain_mode_e'(wdata[2:1]);
            if (wr_nb) begin
                if (wdata == '0)
                    nbands <= NB_W'(1);
                else if (wdata > WORD_W'(MAX_BANDS))
                    nbands <= NB_W'(MAX_BANDS);
                else
                    nbands <= wdata[NB_W-1:0];
            end
            if (finish)
                done <= 1'b1;
            else if (start)
                done <= 1'b0;
            else if (wr_stat && wdata[1])
                done <= 1'b0;
        end
    end

    always_comb begin
        case (reg_off)
            OFF_CTRL:   rdata = WORD_W'({mode, 1'b0});
            OFF_NBANDS: rdata = WORD_W'(nbands);
            OFF_STATUS: rdata = WORD_W'({done, busy});
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/sbg_seq.sv
module sbg_seq
    import sbg_pkg::*;
#(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS),
    localparam int NB_W = BAND_AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NB_W-1:0]    nbands,
    output logic               busy,
    output logic               finish,
    output logic               load,
    output logic               calc,
    output logic [BAND_AW-1:0] idx
);

    seq_state_e state;
    logic       phase;
    logic       last;

    assign last   = ({1'b0, idx} == nbands - NB_W'(1));
    assign busy   = (state != SEQ_IDLE);
    assign finish = (state == SEQ_DRAIN);
    assign load   = (state == SEQ_RUN) && !phase;
    assign calc   = (state == SEQ_RUN) && phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            phase <= 1'b0;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        phase <= 1'b0;
                        idx   <= '0;
                    end
                end
                SEQ_RUN: begin
                    phase <= !phase;
                    if (phase) begin
                        if (last)
                            state <= SEQ_DRAIN;
                        else
                            idx <= idx + BAND_AW'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbg_datapath.sv
module sbg_datapath
    import sbg_pkg::*;
#(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  gain_mode_e         mode,
    input  logic               load,
    input  logic               calc,
    input  logic [BAND_AW-1:0] in_idx,
    input  cplx_t              in_data,
    input  cplx_t              in_gain,
    output logic               we_data,
    output logic               we_energy,
    output logic [BAND_AW-1:0] wr_idx,
    output logic [WORD_W-1:0]  wdata
);

    cplx_t              op_d, op_g;
    logic [BAND_AW-1:0] op_idx;
    logic signed [31:0] p_rr, p_ii, p_ri, p_ir;
    cplx_t              res;
    logic [WORD_W-1:0]  en;

    // stage 1: operand capture; energy mode feeds the sample as its own gain
    always_ff @(posedge clk) begin
        if (rst) begin
            op_d   <= '0;
            op_g   <= '0;
            op_idx <= '0;
        end else if (load) begin
            op_d   <= in_data;
            op_g   <= (mode == MODE_ENERGY) ? in_data : in_gain;
            op_idx <= in_idx;
        end
    end

    always_comb begin
        p_rr = op_d.re * op_g.re;
        p_ii = op_d.im * op_g.im;
        p_ri = op_d.re * op_g.im;
        p_ir = op_d.im * op_g.re;
        en   = 32'(p_rr) + 32'(p_ii);
        if (mode == MODE_CPLX) begin
            res.re = round_sat(34'(p_rr) - 34'(p_ii));
            res.im = round_sat(34'(p_ri) + 34'(p_ir));
        end else begin
            res.re = round_sat(34'(p_rr));
            res.im = round_sat(34'(p_ir));
        end
    end

    // stage 2: result register, written to memory the following cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            we_data   <= 1'b0;
            we_energy <= 1'b0;
            wr_idx    <= '0;
            wdata     <= '0;
        end else begin
            we_data   <= calc && (mode != MODE_ENERGY);
            we_energy <= calc && (mode == MODE_ENERGY);
            if (calc) begin
                wr_idx <= op_idx;
                wdata  <= (mode == MODE_ENERGY) ? en : WORD_W'(res);
            end
        end
    end

endmodule

// File: rtl/subband_gain_engine.sv
module subband_gain_engine
    import sbg_pkg::*;
#(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS),
    localparam int NB_W = BAND_AW + 1,
    localparam int ADDR_W = BAND_AW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq
);

    region_e            region;
    logic [BAND_AW-1:0] h_idx;
    logic               reg_wr;
    logic [WORD_W-1:0]  reg_rdata, h_data, h_gain, h_energy, rd_mux;

    logic               start, busy, finish, done, load, calc;
    gain_mode_e         mode;
    logic [NB_W-1:0]    nbands;
    logic [BAND_AW-1:0] seq_idx, eng_wr_idx;
    cplx_t              e_data, e_gain;
    logic               eng_we_data, eng_we_energy;
    logic [WORD_W-1:0]  eng_wdata;

    assign region = region_e'(host_addr[ADDR_W-1 -: 2]);
    assign h_idx  = host_addr[BAND_AW-1:0];
    assign reg_wr = host_wr && (region == RGN_REGS);
    assign irq    = done;

    sbg_regs #(.MAX_BANDS(MAX_BANDS)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_off(host_addr[1:0]),
        .wdata(host_wdata), .busy(busy), .finish(finish), .start(start),
        .mode(mode), .nbands(nbands), .done(done), .rdata(reg_rdata)
    );

    sbg_seq #(.MAX_BANDS(MAX_BANDS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .nbands(nbands), .busy(busy),
        .finish(finish), .load(load), .calc(calc), .idx(seq_idx)
    );

    sbg_datapath #(.MAX_BANDS(MAX_BANDS)) u_dp (
        .clk(clk), .rst(rst), .mode(mode), .load(load), .calc(calc),
        .in_idx(seq_idx), .in_data(e_data), .in_gain(e_gain),
        .we_data(eng_we_data), .we_energy(eng_we_energy),
        .wr_idx(eng_wr_idx), .wdata(eng_wdata)
    );

    sbg_mem #(.MAX_BANDS(MAX_BANDS)) u_mem (
        .clk(clk),
        .h_we_data(host_wr && (region == RGN_DATA)),
        .h_we_gain(host_wr && (region == RGN_GAIN)),
        .h_we_energy(host_wr && (region == RGN_ENERGY)),
        .h_idx(h_idx), .h_wdata(host_wdata),
        .h_data(h_data), .h_gain(h_gain), .h_energy(h_energy),
        .e_rd_idx(seq_idx), .e_data(e_data), .e_gain(e_gain),
        .e_we_data(eng_we_data), .e_we_energy(eng_we_energy),
        .e_wr_idx(eng_wr_idx), .e_wdata(eng_wdata)
    );

    always_comb begin
        case (region)
            RGN_REGS:   rd_mux = reg_rdata;
            RGN_DATA:   rd_mux = h_data;
            RGN_GAIN:   rd_mux = h_gain;
            default:    rd_mux = h_energy;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= rd_mux;
    end

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
    parameter int MAX_BANDS = 16,
    localparam int BAND_AW = $clog2(MAX_BANDS),
    localparam int NB_W = BAND_AW + 1,
    localparam int ADDR_W = BAND_AW + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [31:0]       host_wdata,
    input logic              irq,
    input logic              busy,
    input logic              done,
    input logic [1:0]        mode,
    input logic [NB_W-1:0]   nbands,
    input logic              we_data,
    input logic              we_energy,
    input logic [BAND_AW-1:0] wr_idx
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2);

    assert_nbands_range_R6: assert property (@(posedge clk) disable iff (rst)
        (nbands >= NB_W'(1)) && (nbands <= NB_W'(MAX_BANDS)));

    assert_write_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (we_data || we_energy) |-> ({1'b0, wr_idx} < nbands));

    assert_single_target_R4: assert property (@(posedge clk) disable iff (rst)
        !(we_data && we_energy));

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode));

    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && !busy));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && (host_addr == STATUS_ADDR) && host_wdata[1] && !busy) |=> !irq);

endmodule

bind subband_gain_engine sbg_checker #(.MAX_BANDS(MAX_BANDS)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .irq(irq), .busy(busy), .done(done),
    .mode(mode), .nbands(nbands), .we_data(eng_we_data),
    .we_energy(eng_we_energy), .wr_idx(eng_wr_idx)
);

// File: tb/subband_gain_engine_test.sv
module subband_gain_engine_test;

    localparam int NB = 8;
    localparam int AW = 5;
    localparam logic [AW-1:0] A_CTRL = 5'd0;
    localparam logic [AW-1:0] A_NB   = 5'd1;
    localparam logic [AW-1:0] A_STAT = 5'd2;
    localparam int DATA_B = 8, GAIN_B = 16, EN_B = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_data [NB];
    logic [31:0] m_gain [NB];
    logic [31:0] m_en   [NB];

    always #10 clk = ~clk;

    subband_gain_engine #(.MAX_BANDS(NB)) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [15:0] rsat(input longint acc);
        longint r;
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r[15:0];
    endfunction

    function automatic longint sx(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [31:0] exp_word(input int mode, input logic [31:0] d, input logic [31:0] g);
        longint dr, di, gr, gi;
        dr = sx(d[31:16]); di = sx(d[15:0]); gr = sx(g[31:16]); gi = sx(g[15:0]);
        if (mode == 2) return 32'(dr*dr + di*di);
        if (mode == 1) return {rsat(dr*gr - di*gi), rsat(dr*gi + di*gr)};
        return {rsat(dr*gr), rsat(di*gr)};
    endfunction

    // mode: 0 real (R2), 1 complex (R3), 2 energy (R4)
    task automatic run_pass(input int mode, input int nb_req, input bit corner, input bit restart);
        int nb_eff, cyc;
        logic [31:0] v, w;
        string tag;
        for (int i = 0; i < NB; i++) begin
            m_data[i] = $urandom; m_gain[i] = $urandom; m_en[i] = $urandom;
            if (corner && i == 0) begin m_data[i] = 32'h80008000; m_gain[i] = 32'h80008000; end
            if (corner && i == 1) begin m_data[i] = 32'h7FFF8000; m_gain[i] = 32'h80007FFF; end
            if (corner && i == 2) begin m_data[i] = 32'h00010001; m_gain[i] = 32'h40004000; end
            wr(AW'(DATA_B + i), m_data[i]);
            wr(AW'(GAIN_B + i), m_gain[i]);
            wr(AW'(EN_B + i), m_en[i]);
        end
        wr(A_NB, 32'(nb_req));
        nb_eff = (nb_req == 0) ? 1 : (nb_req > NB ? NB : nb_req);
        wr(A_CTRL, 32'((mode << 1) | 1));
        cyc = 1;
        if (irq !== 1'b0) chk("R9 start clears done", {31'b0, irq}, 32'd0);
        while (!irq && cyc < 1000) begin
            if (restart && cyc == 4) begin
                host_addr = A_CTRL; host_wdata = 32'h5; host_wr = 1'b1;
            end
            @(negedge clk);
            host_wr = 1'b0;
            cyc++;
        end
        chk("R7 latency", 32'(cyc - 1), 32'(2 * nb_eff + 1));
        chk("R7 irq", {31'b0, irq}, 32'd1);
        for (int i = 0; i < nb_eff; i++) begin
            if (mode == 2) m_en[i] = exp_word(2, m_data[i], m_data[i]);
            else m_data[i] = exp_word(mode, m_data[i], m_gain[i]);
        end
        tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R4";
        for (int i = 0; i < NB; i++) begin
            rd(AW'(DATA_B + i), v);
            rd(AW'(EN_B + i), w);
            chk(i < nb_eff ? tag : "R5", v, m_data[i]);
            chk(i < nb_eff ? tag : "R5", w, m_en[i]);
        end
        if (restart) begin
            rd(A_CTRL, v);
            chk("R8 mode kept", v, 32'(mode << 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R10
        rd(A_STAT, v); chk("R1 status", v, 32'd0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
        rd(A_NB, v);   chk("R1 nbands", v, 32'(NB));
        chk("R1 irq", {31'b0, irq}, 32'd0);
        // R6 clamp
        wr(A_NB, 32'd0);  rd(A_NB, v); chk("R6 zero", v, 32'd1);
        wr(A_NB, 32'd20); rd(A_NB, v); chk("R6 high", v, 32'(NB));
        wr(A_NB, 32'd5);  rd(A_NB, v); chk("R6 mid", v, 32'd5);
        // directed passes with corner values
        run_pass(0, NB, 1'b1, 1'b0); wr(A_STAT, 32'h2);
        run_pass(1, NB, 1'b1, 1'b0); wr(A_STAT, 32'h2);
        run_pass(2, NB, 1'b1, 1'b0); wr(A_STAT, 32'h2);
        run_pass(1, 3, 1'b0, 1'b0);  wr(A_STAT, 32'h2);
        run_pass(0, 1, 1'b0, 1'b0);  wr(A_STAT, 32'h2);
        run_pass(2, 5, 1'b0, 1'b0);
        // R9: write without bit 1 leaves done, with bit 1 clears it
        wr(A_STAT, 32'h1);
        chk("R9 keep", {31'b0, irq}, 32'd1);
        wr(A_STAT, 32'h2);
        chk("R9 clear", {31'b0, irq}, 32'd0);
        rd(A_STAT, v); chk("R9 status", v, 32'd0);
        // R8: start request during a pass is ignored
        run_pass(0, NB, 1'b0, 1'b1); wr(A_STAT, 32'h2);
        // R9: next start clears a pending done
        run_pass(1, 4, 1'b0, 1'b0);
        run_pass(2, 6, 1'b0, 1'b0);  wr(A_STAT, 32'h2);
        // random passes
        for (int k = 0; k < 8; k++) begin
            run_pass(int'($urandom % 3), int'($urandom % 10), 1'b0, 1'b0);
            wr(A_STAT, 32'h2);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule